// File: doc/BRIEF.md
# Hardwired Accumulator Instruction Sequencer

This block is the control unit and register datapath of a minimal single-accumulator processor. A hardwired timing counter steps through a fixed set of timing states. Each register load is bound to exactly one of those states, and no control memory is involved. The register set is a program counter, a memory address register, a memory data register, an instruction register and an accumulator. The block reads instruction words and operands through a simple synchronous memory port: it presents an address, and the memory returns that word on the read-data input one clock later.

Every instruction begins with the same three-state fetch. In state `S_ADDR` (T0) the PC is copied into MAR. In `S_READ` (T1) the fetched word lands in MDR and the PC steps by one. In `S_LATCH` (T2) MDR is copied into IR. The decode state `S_DECODE` (T3) is where behaviour splits on the opcode in IR[15:12]:
- ADD (`4'h1`) loads MAR from the address field IR[11:0], then goes to `S_OPREAD` (T4), which reads the operand into MDR, and then to `S_ACCUM` (T5), which adds MDR into AC.
- HALT (`4'hF`) holds the counter in `S_DECODE` and raises `halted`.
- Every other code, including the no-op `4'h0`, goes straight back to `S_ADDR`.

The state transitions are:
- `S_ADDR`→`S_READ`→`S_LATCH`→`S_DECODE`
- `S_DECODE`→`S_OPREAD` (ADD), `S_DECODE`→`S_DECODE` (HALT), `S_DECODE`→`S_ADDR` (other codes)
- `S_OPREAD`→`S_ACCUM`→`S_ADDR`

The timing state is visible on `tstate` as T-number n encoded as the value n.

Top module: `acc_seq_top`

## Requirements
- R1: While `rst_n` is low, the block is held as follows: `pc` = 0, `acc` = 0, `tstate` = 0 (`S_ADDR`) and `halted` = 0. After `rst_n` is released the block starts fetching at address 0.
- R2: In `S_ADDR` (tstate 0), `mem_addr` equals `pc`. The memory must return the word at `mem_addr` on `mem_rdata` in the following cycle.
- R3: The PC changes only at the end of `S_READ` (tstate 1), and it changes by exactly +1. Within the cycle that has tstate 2, `pc` already shows the incremented value.
- R4: The fetch is the same for every opcode: states 0, 1 and 2 follow one another on consecutive cycles, and the cycle after state 2 is state 3.
- R5: For ADD (IR[15:12] = 4'h1), state 3 presents IR[11:0] on `mem_addr`. The states that follow are 4 and then 5. At the end of state 5, AC becomes AC + M[IR[11:0]] modulo 2^16, and the next state is 0. AC changes in no other state. A full ADD takes 6 cycles.
- R6: For any opcode other than ADD or HALT (including the no-op 4'h0), the cycle after state 3 is state 0, and AC is unchanged. Such an instruction takes 4 cycles.
- R7: For HALT (IR[15:12] = 4'hF), `halted` rises in the first state-3 cycle. It stays high with `tstate` at 3 and `pc` and `acc` frozen until reset. A program consisting of two ADDs and then a HALT shows `halted` 15 cycles after reset release.
- R8: The PC wraps from 4095 to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory read address; the word is expected on mem_rdata one cycle later |
| mem_rdata | input | 16 | Memory read data |
| acc | output | 16 | Accumulator value |
| pc | output | 12 | Program counter value |
| tstate | output | 3 | Current timing state number (0 to 5) |
| halted | output | 1 | High while the sequencer is stopped on a HALT |

## Verification
The assertions check the following on every cycle:
- the fetch order of states 0, 1 and 2;
- that the PC moves only in state 1, by one with wrap;
- that AC moves only in state 5;
- the return to state 0 after state 5;
- the address shown in state 0;
- the frozen registers and state while halted.

Only the bench scenarios can show that the memory-read latency actually delivers the right words. This covers the arithmetic results, including the modular carry-out cases. They also show the cycle count up to HALT, that undefined and no-op codes return early without touching AC, that reset clears a halted machine, and the PC wrap after 4096 fetches.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP  = 4'h0;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
    localparam logic [OP_W-1:0] OP_HALT = 4'hF;

    typedef enum logic [2:0] {
        S_ADDR   = 3'd0,
        S_READ   = 3'd1,
        S_LATCH  = 3'd2,
        S_DECODE = 3'd3,
        S_OPREAD = 3'd4,
        S_ACCUM  = 3'd5
    } tstate_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mdr_load;
        logic pc_inc;
        logic ir_load;
        logic acc_add;
    } ctl_t;

endpackage

// File: rtl/acc_seq_timing.sv
module acc_seq_timing
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output tstate_e         state
);

    tstate_e state_q;
    tstate_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = S_ADDR;
        unique case (state_q)
            S_ADDR:   state_d = S_READ;
            S_READ:   state_d = S_LATCH;
            S_LATCH:  state_d = S_DECODE;
            S_DECODE: begin
                if (opcode == OP_ADD) begin
                    state_d = S_OPREAD;
                end else if (opcode == OP_HALT) begin
                    state_d = S_DECODE;
                end else begin
                    state_d = S_ADDR;
                end
            end
            S_OPREAD: state_d = S_ACCUM;
            S_ACCUM:  state_d = S_ADDR;
            default:  state_d = S_ADDR;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  tstate_e         state,
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl,
    output logic            halted
);

    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state)
            S_ADDR:   ctl.mar_from_pc = 1'b1;
            S_READ: begin
                ctl.mdr_load = 1'b1;
                ctl.pc_inc   = 1'b1;
            end
            S_LATCH:  ctl.ir_load = 1'b1;
            S_DECODE: begin
                if (opcode == OP_ADD) begin
                    ctl.mar_from_ir = 1'b1;
                end
                if (opcode == OP_HALT) begin
                    halted = 1'b1;
                end
            end
            S_OPREAD: ctl.mdr_load = 1'b1;
            S_ACCUM:  ctl.acc_add  = 1'b1;
            default:  ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = OP_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [ADDR_W-1:0] mar_d;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;

    // The next MAR value is what the memory registers, so the word it
    // returns is ready in the state that loads MDR.
    always_comb begin
        if (ctl.mar_from_pc) begin
            mar_d = pc_q;
        end else if (ctl.mar_from_ir) begin
            mar_d = ir_q[ADDR_W-1:0];
        end else begin
            mar_d = mar_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            mar_q <= mar_d;
            if (ctl.pc_inc) begin
                pc_q <= pc_q + 1'b1;
            end
            if (ctl.mdr_load) begin
                mdr_q <= mem_rdata;
            end
            if (ctl.ir_load) begin
                ir_q <= mdr_q;
            end
            if (ctl.acc_add) begin
                acc_q <= acc_q + mdr_q;
            end
        end
    end

    assign mem_addr = mar_d;
    assign opcode   = ir_q[DATA_W-1 -: OP_W];
    assign pc_o     = pc_q;
    assign acc_o    = acc_q;

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = OP_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic [2:0]        tstate,
    output logic              halted
);

    tstate_e         state;
    ctl_t            ctl;
    logic [OP_W-1:0] opcode;

    acc_seq_timing u_timing (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .state  (state)
    );

    acc_seq_decode u_decode (
        .state  (state),
        .opcode (opcode),
        .ctl    (ctl),
        .halted (halted)
    );

    acc_seq_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .opcode    (opcode),
        .pc_o      (pc),
        .acc_o     (acc)
    );

    assign tstate = state;

endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] pc,
    input logic [2:0]        tstate,
    input logic              halted
);

    p_t0_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd0) |-> (mem_addr == pc));

    p_fetch_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate < 3'd3) |=> (tstate == $past(tstate) + 3'd1));

    // Step by one with natural wrap at the address width (also R8).
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd1) |=> (pc == $past(pc) + 1'b1));

    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate != 3'd1) |=> $stable(pc));

    p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate != 3'd5) |=> $stable(acc));

    p_accum_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd5) |=> (tstate == 3'd0));

    p_halt_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (tstate == 3'd3));

    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc)));

endmodule

bind acc_seq_top acc_seq_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .acc      (acc),
    .pc       (pc),
    .tstate   (tstate),
    .halted   (halted)
);

// File: tb/tb_acc_seq_top.sv
module tb_acc_seq_top;

    localparam int AW    = 12;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 6;

    // {operand a, operand b, expected AC}
    localparam logic [47:0] VECS [NVEC] = '{
        {16'h0001, 16'h0002, 16'h0003},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h8000, 16'h8000, 16'h0000},
        {16'h1234, 16'h4321, 16'h5555},
        {16'h0000, 16'h0000, 16'h0000},
        {16'h7FFF, 16'h0001, 16'h8000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] acc;
    logic [AW-1:0] pc;
    logic [2:0]    tstate;
    logic          halted;

    logic [DW-1:0] mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    acc_seq_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .acc       (acc),
        .pc        (pc),
        .tstate    (tstate),
        .halted    (halted)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) act=%0d exp<=150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_to_halt(output int n);
        n = 0;
        while (!halted && n < 200) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        int n;
        clear_mem();

        // R1: state held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc == 12'd0, "R1 pc in reset", 32'(pc), 32'd0);
        check(acc == 16'd0, "R1 acc in reset", 32'(acc), 32'd0);
        check(tstate == 3'd0, "R1 tstate in reset", 32'(tstate), 32'd0);
        check(halted == 1'b0, "R1 halted in reset", 32'(halted), 32'd0);
        check(mem_addr == 12'd0, "R2 mem_addr in reset", 32'(mem_addr), 32'd0);

        // Vector table: ADD a; ADD b; HALT
        for (int v = 0; v < NVEC; v++) begin
            clear_mem();
            mem[0]      = 16'h1100;
            mem[1]      = 16'h1101;
            mem[2]      = 16'hF000;
            mem[12'h100] = VECS[v][47:32];
            mem[12'h101] = VECS[v][31:16];
            do_reset();
            run_to_halt(n);
            check(n == 15, "R4 cycles to halt", 32'(n), 32'd15);
            check(acc == VECS[v][15:0], "R5 sum", 32'(acc), 32'(VECS[v][15:0]));
            check(pc == 12'd3, "R3 pc at halt", 32'(pc), 32'd3);
        end

        // Directed timing trace of one ADD followed by HALT
        clear_mem();
        mem[0]       = 16'h1100;
        mem[1]       = 16'hF000;
        mem[12'h100] = 16'h0042;
        do_reset();
        check(tstate == 3'd0 && mem_addr == pc, "R2 T0 address",
              {17'd0, tstate, mem_addr}, {17'd0, 3'd0, pc});
        step(1);
        check(tstate == 3'd1 && pc == 12'd0, "R3 T1 pc not yet stepped",
              {17'd0, tstate, pc}, {17'd0, 3'd1, 12'd0});
        step(1);
        check(tstate == 3'd2 && pc == 12'd1, "R3 T2 pc stepped",
              {17'd0, tstate, pc}, {17'd0, 3'd2, 12'd1});
        step(1);
        check(tstate == 3'd3 && mem_addr == 12'h100, "R5 T3 operand address",
              {17'd0, tstate, mem_addr}, {17'd0, 3'd3, 12'h100});
        step(1);
        check(tstate == 3'd4, "R5 T4", 32'(tstate), 32'd4);
        step(1);
        check(tstate == 3'd5 && acc == 16'd0, "R5 T5 acc not yet added",
              {13'd0, tstate, acc}, {13'd0, 3'd5, 16'd0});
        step(1);
        check(tstate == 3'd0 && acc == 16'h0042, "R5 back to T0 with sum",
              {13'd0, tstate, acc}, {13'd0, 3'd0, 16'h0042});
        run_to_halt(n);
        check(n == 3 && halted, "R7 halt after fetch", 32'(n), 32'd3);
        step(20);
        check(halted && tstate == 3'd3, "R7 still halted in T3",
              {28'd0, halted, tstate}, {28'd0, 1'b1, 3'd3});
        check(pc == 12'd2 && acc == 16'h0042, "R7 registers frozen",
              {4'd0, pc, acc}, {4'd0, 12'd2, 16'h0042});

        // R1: reset out of the halted state
        rst_n = 1'b0;
        step(2);
        check(!halted && pc == 12'd0 && acc == 16'd0 && tstate == 3'd0,
              "R1 reset clears halted machine",
              {halted, pc, acc, tstate}, 32'd0);
        rst_n = 1'b1;

        // R6: undefined opcode and no-op return after T3 without touching AC
        clear_mem();
        mem[0]       = 16'h7100;
        mem[1]       = 16'h0000;
        mem[2]       = 16'h1100;
        mem[3]       = 16'hF000;
        mem[12'h100] = 16'h0005;
        do_reset();
        step(3);
        check(tstate == 3'd3, "R6 undefined decoded", 32'(tstate), 32'd3);
        step(1);
        check(tstate == 3'd0 && acc == 16'd0, "R6 undefined returns to T0",
              {13'd0, tstate, acc}, 32'd0);
        run_to_halt(n);
        check(n == 13, "R6 no-op length", 32'(n), 32'd13);
        check(acc == 16'h0005, "R6 acc after no-op path", 32'(acc), 32'h5);

        // R8: PC wraps after 4096 no-op fetches
        clear_mem();
        do_reset();
        step(16378);
        check(pc == 12'd4095, "R8 pc at top", 32'(pc), 32'd4095);
        step(4);
        check(pc == 12'd0, "R8 pc wrapped", 32'(pc), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule